// File: doc/BRIEF.md
# Deferred-Commit Store Buffer with Load Merge

This block is a one-entry holding register placed between a store pipeline and a data cache array that has a single port. When a store arrives, its address, data and byte enables are captured in the same cycle that the tag compare for that store resolves. If the compare reports a hit, the entry becomes valid. If it reports a miss, the store is dropped here and left to the miss path. A valid entry is written into the array in the first later cycle in which no load is reading the array. Loads therefore always get the port and are never delayed by pending store data.

Stores are accepted every cycle without a ready signal. A store cycle never reads the array, so a store that arrives while the entry is occupied pushes the old entry into the array in that same cycle and takes its place. A load issued while the entry is valid reads the array as usual. If the load address equals the buffered address, the returned word takes the buffered bytes where their enables are set and the array bytes elsewhere, so a load right after a store to the same word sees the new data with no extra latency. The buffered entry then commits in the next cycle that has no load, which can be the same cycle the merged data is returned.

The array is synchronous: read data arrives one cycle after the read request, and a write takes effect at the clock edge that ends the write cycle. Store and load requests are mutually exclusive in any cycle.

Top module: `store_merge_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset with no request, arrWrEn and ldValid are 0; reset discards any buffered entry, so it is never written.
- R2: A store with stTagHit=1 is captured in its own cycle. It is not written in that cycle if the buffer was empty. It is written with its address, data and byte enables (arrWrAddr, arrWrData, arrWrBen) in the next cycle without ldReq.
- R3: A store with stTagHit=0 is discarded. It never produces a write to the array, and an entry that was already valid still commits in that cycle.
- R4: In a cycle with ldReq=1, arrWrEn is 0, arrRdEn is 1 and arrRdAddr equals ldAddr. A valid entry is held across any run of load cycles.
- R5: Stores are accepted every cycle. A store cycle that finds a valid entry writes that entry to the array in the same cycle, so back-to-back hit stores are each written exactly once, in order.
- R6: ldValid is 1 in the cycle after a cycle with ldReq=1 and 0 otherwise.
- R7: For a load whose address equals the valid entry's address, byte b of ldData (bits 8b+7 down to 8b) is the buffered byte when buffered enable bit b is 1, and the array byte when it is 0.
- R8: For a load with no valid entry at its address, ldData equals the array read data. This includes data that an earlier commit has written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stReq | input | 1 | Store request this cycle |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data |
| stBen | input | DATA_W/8 | Store byte enables |
| stTagHit | input | 1 | Tag compare result for the store in this cycle |
| ldReq | input | 1 | Load request this cycle |
| ldAddr | input | ADDR_W | Load word address |
| arrRdEn | output | 1 | Array read enable |
| arrRdAddr | output | ADDR_W | Array read address |
| arrRdData | input | DATA_W | Array read data, one cycle after arrRdEn |
| arrWrEn | output | 1 | Array write enable |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | DATA_W | Array write data |
| arrWrBen | output | DATA_W/8 | Array write byte enables |
| ldValid | output | 1 | Load data valid |
| ldData | output | DATA_W | Merged load data |

## Verification
The checker tests the following on every cycle: a load cycle never writes and always drives the read port; ldValid follows the load request one cycle later; a tag-miss store leaves the following cycle without a write; a hit store is written in the following cycle unless a load intervenes; and a store arriving on a valid entry forces a commit. Byte-level merge correctness, the ordering and single delivery of a chain of stores, write-then-read consistency through the array, and the discard on reset can only be shown by the bench's scenarios. The bench compares these against its own model of the entry and the array.

// File: rtl/smb_pkg.sv
package smb_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic capture;    // load entry registers from the store inputs
    logic commit;     // entry drives the array write port this cycle
    logic entryValid; // entry currently holds a tag-hit store
    logic loadNow;    // a load is using the array this cycle
  } sbStrobe_t;
endpackage

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stReq,
  input  logic      stTagHit,
  input  logic      ldReq,
  output sbStrobe_t strobe,
  output logic      ldValid
);
  logic validQ;
  logic validD;
  logic captureNow;
  logic commitNow;

  // A tag-hit store always takes the entry; a miss is dropped here
  assign captureNow = stReq & stTagHit;
  // The array port is free whenever no load is reading it
  assign commitNow  = validQ & ~ldReq;
  assign validD     = captureNow | (validQ & ~commitNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      ldValid <= 1'b0;
    end else begin
      validQ  <= validD;
      ldValid <= ldReq;
    end
  end

  always_comb begin
    strobe.capture    = captureNow;
    strobe.commit     = commitNow;
    strobe.entryValid = validQ;
    strobe.loadNow    = ldReq;
  end
endmodule

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BYTES-1:0]  stBen,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic [BYTES-1:0]  arrWrBen,
  output logic [DATA_W-1:0] ldData
);
  logic [ADDR_W-1:0] entryAddr;
  logic [DATA_W-1:0] entryData;
  logic [BYTES-1:0]  entryBen;
  logic [BYTES-1:0]  mergeMaskD;
  logic [BYTES-1:0]  mergeMaskQ;
  logic              addrMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryAddr <= '0;
      entryData <= '0;
      entryBen  <= '0;
    end else if (strobe.capture) begin
      entryAddr <= stAddr;
      entryData <= stData;
      entryBen  <= stBen;
    end
  end

  // Entry is frozen during a load cycle (no capture, no commit),
  // so only the byte mask needs registering for the return cycle.
  assign addrMatch  = strobe.entryValid & strobe.loadNow & (ldAddr == entryAddr);
  assign mergeMaskD = addrMatch ? entryBen : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mergeMaskQ <= '0;
    else       mergeMaskQ <= mergeMaskD;
  end

  assign arrWrAddr = entryAddr;
  assign arrWrData = entryData;
  assign arrWrBen  = entryBen;

  for (genvar b = 0; b < BYTES; b++) begin : g_mergeByte
    assign ldData[b*8 +: 8] = mergeMaskQ[b] ? entryData[b*8 +: 8] : arrRdData[b*8 +: 8];
  end
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer
  import smb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stReq,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [DATA_W-1:0]     stData,
  input  logic [DATA_W/8-1:0]   stBen,
  input  logic                  stTagHit,
  input  logic                  ldReq,
  input  logic [ADDR_W-1:0]     ldAddr,
  output logic                  arrRdEn,
  output logic [ADDR_W-1:0]     arrRdAddr,
  input  logic [DATA_W-1:0]     arrRdData,
  output logic                  arrWrEn,
  output logic [ADDR_W-1:0]     arrWrAddr,
  output logic [DATA_W-1:0]     arrWrData,
  output logic [DATA_W/8-1:0]   arrWrBen,
  output logic                  ldValid,
  output logic [DATA_W-1:0]     ldData
);
  sbStrobe_t strobe;

  smb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stReq    (stReq),
    .stTagHit (stTagHit),
    .ldReq    (ldReq),
    .strobe   (strobe),
    .ldValid  (ldValid)
  );

  smb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .stAddr    (stAddr),
    .stData    (stData),
    .stBen     (stBen),
    .ldAddr    (ldAddr),
    .arrRdData (arrRdData),
    .arrWrAddr (arrWrAddr),
    .arrWrData (arrWrData),
    .arrWrBen  (arrWrBen),
    .ldData    (ldData)
  );

  assign arrWrEn   = strobe.commit;
  assign arrRdEn   = ldReq;
  assign arrRdAddr = ldAddr;
endmodule

// File: rtl/smb_checker.sv
module smb_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              stReq,
  input logic [ADDR_W-1:0] stAddr,
  input logic [DATA_W-1:0] stData,
  input logic              stTagHit,
  input logic              ldReq,
  input logic [ADDR_W-1:0] ldAddr,
  input logic              arrRdEn,
  input logic [ADDR_W-1:0] arrRdAddr,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr,
  input logic [DATA_W-1:0] arrWrData,
  input logic              ldValid
);
  // R4
  no_wr_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq |-> (!arrWrEn && arrRdEn && arrRdAddr == ldAddr));

  // R6
  ld_valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq |=> ldValid);

  // R6
  ld_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldReq |=> !ldValid);

  // R3
  miss_no_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stReq && !stTagHit) |=> !arrWrEn);

  // R2
  hit_commit_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stReq && stTagHit) |=>
      (ldReq || (arrWrEn && arrWrAddr == $past(stAddr) && arrWrData == $past(stData))));

  // R5
  store_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stReq && $past(rstN) && $past(stReq && stTagHit)) |-> arrWrEn);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!arrWrEn && !ldValid));
endmodule

bind store_merge_buffer smb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smbChk (
  .clk       (clk),
  .rstN      (rstN),
  .stReq     (stReq),
  .stAddr    (stAddr),
  .stData    (stData),
  .stTagHit  (stTagHit),
  .ldReq     (ldReq),
  .ldAddr    (ldAddr),
  .arrRdEn   (arrRdEn),
  .arrRdAddr (arrRdAddr),
  .arrWrEn   (arrWrEn),
  .arrWrAddr (arrWrAddr),
  .arrWrData (arrWrData),
  .ldValid   (ldValid)
);

// File: tb/test_store_merge_buffer.sv
`timescale 1ns/1ps
module test_store_merge_buffer;
  localparam int AW = 4;
  localparam int DW = 64;
  localparam int BW = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stReq = 1'b0, stTagHit = 1'b0, ldReq = 1'b0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [DW-1:0] stData = '0;
  logic [BW-1:0] stBen = '0;
  logic          arrRdEn, arrWrEn, ldValid;
  logic [AW-1:0] arrRdAddr, arrWrAddr;
  logic [DW-1:0] arrRdData, arrWrData, ldData;
  logic [BW-1:0] arrWrBen;

  always #4 clk = ~clk; // 125 MHz

  store_merge_buffer #(.ADDR_W(AW), .DATA_W(DW)) i_store_merge_buffer (
    .clk(clk), .rstN(rstN), .stReq(stReq), .stAddr(stAddr), .stData(stData),
    .stBen(stBen), .stTagHit(stTagHit), .ldReq(ldReq), .ldAddr(ldAddr),
    .arrRdEn(arrRdEn), .arrRdAddr(arrRdAddr), .arrRdData(arrRdData),
    .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData),
    .arrWrBen(arrWrBen), .ldValid(ldValid), .ldData(ldData)
  );

  // Behavioural synchronous array
  logic [DW-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (arrWrEn)
      for (int b = 0; b < BW; b++)
        if (arrWrBen[b]) mem[arrWrAddr][b*8 +: 8] <= arrWrData[b*8 +: 8];
    if (arrRdEn) arrRdData <= mem[arrRdAddr];
  end

  // Bench reference state
  logic [DW-1:0] refMem [DEPTH];
  logic          refValid;
  logic [AW-1:0] refAddr;
  logic [DW-1:0] refData;
  logic [BW-1:0] refBen;
  logic          pendLd;
  logic [DW-1:0] pendExp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mergeBytes(input logic [DW-1:0] base, input logic [DW-1:0] ovr, input logic [BW-1:0] m);
    logic [DW-1:0] r = base;
    for (int b = 0; b < BW; b++) if (m[b]) r[b*8 +: 8] = ovr[b*8 +: 8];
    return r;
  endfunction

  // One cycle: drive at negedge, check before the next posedge, advance the model
  task automatic stepCycle(input logic st, input logic hit, input logic ld, input logic [AW-1:0] addr,
                           input logic [DW-1:0] data, input logic [BW-1:0] ben,
                           input bit useExp, input logic expW, input string tag);
    logic refWr;
    logic [BW-1:0] m;
    @(negedge clk);
    stReq = st; stTagHit = hit; stAddr = addr; stData = data; stBen = ben;
    ldReq = ld; ldAddr = addr;
    #1;
    refWr = refValid && !ld;
    chk(arrWrEn == (useExp ? expW : refWr), {tag, " R2 R3 R4 R5 write enable"}, 64'(arrWrEn), 64'(useExp ? expW : refWr));
    if (refWr) begin
      chk(arrWrAddr == refAddr, {tag, " R2 write address"}, 64'(arrWrAddr), 64'(refAddr));
      chk(arrWrData == refData, {tag, " R2 write data"}, arrWrData, refData);
      chk(arrWrBen == refBen, {tag, " R2 write byte enables"}, 64'(arrWrBen), 64'(refBen));
    end
    if (ld) chk(arrRdEn && arrRdAddr == addr, {tag, " R4 read port"}, 64'(arrRdAddr), 64'(addr));
    chk(ldValid == pendLd, {tag, " R6 ldValid"}, 64'(ldValid), 64'(pendLd));
    if (pendLd) chk(ldData == pendExp, {tag, " R7 R8 load data"}, ldData, pendExp);
    // advance model
    if (ld) begin
      m = (refValid && refAddr == addr) ? refBen : '0;
      pendExp = mergeBytes(refMem[addr], refData, m);
    end
    pendLd = ld;
    if (refWr) refMem[refAddr] = mergeBytes(refMem[refAddr], refData, refBen);
    if (st && hit) begin
      refValid = 1'b1; refAddr = addr; refData = data; refBen = ben;
    end else if (refWr) refValid = 1'b0;
  endtask

  typedef struct packed {
    logic st; logic hit; logic ld;
    logic [AW-1:0] addr; logic [DW-1:0] data; logic [BW-1:0] ben;
    logic expWr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 4'h3, 64'h1111_2222_3333_4444, 8'hFF, 1'b0}, // R2 capture, empty
    '{1'b0, 1'b0, 1'b1, 4'h3, 64'h0,                   8'h00, 1'b0}, // R4 R7 full merge
    '{1'b0, 1'b0, 1'b0, 4'h0, 64'h0,                   8'h00, 1'b1}, // R2 commit
    '{1'b1, 1'b1, 1'b0, 4'h5, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F, 1'b0}, // R2
    '{1'b1, 1'b1, 1'b0, 4'h6, 64'h5555_6666_7777_8888, 8'hF0, 1'b1}, // R5 push
    '{1'b1, 1'b1, 1'b0, 4'h7, 64'h9999_0000_EEEE_FFFF, 8'hFF, 1'b1}, // R5 push
    '{1'b0, 1'b0, 1'b1, 4'h7, 64'h0,                   8'h00, 1'b0}, // R7
    '{1'b0, 1'b0, 1'b1, 4'h2, 64'h0,                   8'h00, 1'b0}, // R4 hold, R8
    '{1'b1, 1'b0, 1'b0, 4'h9, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF, 1'b1}, // R3 old commits
    '{1'b0, 1'b0, 1'b0, 4'h0, 64'h0,                   8'h00, 1'b0}, // R3 dropped
    '{1'b0, 1'b0, 1'b1, 4'h5, 64'h0,                   8'h00, 1'b0}, // R8 after commit
    '{1'b1, 1'b1, 1'b0, 4'h4, 64'h0102_0304_0506_0708, 8'h3C, 1'b0}, // R2
    '{1'b0, 1'b0, 1'b1, 4'h4, 64'h0,                   8'h00, 1'b0}, // R7 partial
    '{1'b0, 1'b0, 1'b0, 4'h0, 64'h0,                   8'h00, 1'b1}, // R2 commit
    '{1'b0, 1'b0, 1'b1, 4'h4, 64'h0,                   8'h00, 1'b0}, // R8 read back
    '{1'b0, 1'b0, 1'b0, 4'h0, 64'h0,                   8'h00, 1'b0}  // R6 return
  };

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = {32'hC0DE_0000 | 32'(i), 32'h1234_5600 | 32'(i)};
      refMem[i] = {32'hC0DE_0000 | 32'(i), 32'h1234_5600 | 32'(i)};
    end
    refValid = 1'b0; refAddr = '0; refData = '0; refBen = '0;
    pendLd = 1'b0; pendExp = '0;

    // R1: quiet during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!arrWrEn && !ldValid, "R1 outputs in reset", 64'({arrWrEn, ldValid}), 64'(0));
    rstN = 1'b1;
    stepCycle(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R1 first cycle");

    for (int v = 0; v < NV; v++)
      stepCycle(VEC[v].st, VEC[v].hit, VEC[v].ld, VEC[v].addr, VEC[v].data, VEC[v].ben,
                1'b1, VEC[v].expWr, $sformatf("vec%0d", v));

    // R4: entry held across a run of loads to other addresses, then commits
    stepCycle(1'b1, 1'b1, 1'b0, 4'hA, 64'hFEED_FACE_0BAD_F00D, 8'h81, 1'b1, 1'b0, "R2 capture");
    for (int k = 0; k < 4; k++)
      stepCycle(1'b0, 1'b0, 1'b1, 4'(k), '0, '0, 1'b1, 1'b0, "R4 held");
    stepCycle(1'b0, 1'b0, 1'b1, 4'hA, '0, '0, 1'b1, 1'b0, "R7 after held");
    stepCycle(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b1, "R2 late commit");
    stepCycle(1'b0, 1'b0, 1'b1, 4'hA, '0, '0, 1'b1, 1'b0, "R8 reread");
    stepCycle(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R6 tail");

    // R1: reset drops a valid entry
    stepCycle(1'b1, 1'b1, 1'b0, 4'hB, 64'h7777_7777_7777_7777, 8'hFF, 1'b1, 1'b0, "R1 pre-reset store");
    @(negedge clk);
    stReq = 1'b0; stTagHit = 1'b0; ldReq = 1'b0;
    rstN = 1'b0;
    #1;
    chk(!arrWrEn, "R1 no write in reset", 64'(arrWrEn), 64'(0));
    @(negedge clk);
    rstN = 1'b1;
    refValid = 1'b0; pendLd = 1'b0;
    stepCycle(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R1 entry dropped");
    stepCycle(1'b0, 1'b0, 1'b1, 4'hB, '0, '0, 1'b1, 1'b0, "R1 R8 word untouched");
    stepCycle(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R6 final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule